// File: doc/BRIEF.md
# Reload Timer with Programmable Pulse Output

This block is a 16-bit down-counting timer. It reloads itself from a latch and drives one output pin. The count clock is the system clock divided by a selectable power of two. Each time the counter passes zero, the block reloads the counter from the latch and raises a one-cycle underflow interrupt. A byte-wide register bus programs the block through a control byte, a prescaler select, and a latch written as a low byte and then a high byte. The same bus reads back the live counter.

The pin has two modes. In waveform mode, software writes a level bit, and each underflow copies that bit onto the pin. Software rewrites the level bit and the latch after each underflow to build any waveform it needs. In one-shot mode, a chosen edge on the trigger input drives the pin to its active level, reloads the counter and starts a pulse. The next underflow returns the pin to its inactive level. A polarity bit sets which level is active. All other mode codes release the pin.

Top module: `pulse_reload_timer`

## Requirements
- R1: After reset, the pin output and the pin enable are 0, both interrupts are 0, the counter reads 0, and the write-control bit selects immediate loading.
- R2: Control bits [2:0] select the mode. 3'b100 is waveform mode and 3'b101 is one-shot mode, and in both `pin_oe` is 1. Any other code, including 3'b000, sets `pin_oe` to 0 and holds `pin_out` at 0.
- R3: The prescaler select at address 3 takes a value k from 0 to 9 and divides the clock by 2^(k+1). Values above 9 act as 9. The counter counts only when the run bit (control bit 7) is 1 and a pin mode is selected. With latch value L, underflows come every (L+1)*2^(k+1) clock cycles.
- R4: At each underflow the counter reloads from the latch, and `irq_uf` is high for exactly one cycle.
- R5: In waveform mode, each underflow copies the level bit (control bit 4) onto `pin_out`. Between underflows the pin holds its value, even when the level bit is rewritten.
- R6: When the mode changes into one-shot, `pin_out` takes the polarity bit (control bit 5) as its inactive level. With 0 the pin idles low; with 1 it idles high.
- R7: In one-shot mode, a valid trigger edge drives `pin_out` to the inverse of the polarity bit and reloads the counter from the latch. It also pulses `irq_trig` for one cycle. The next underflow returns the pin to the polarity bit.
- R8: Control bit 6 selects the trigger edge: 1 selects the rising edge and 0 the falling edge. The opposite edge has no effect on the pin or on `irq_trig`.
- R9: A trigger that arrives while the run bit is 0 still drives the pin to its active level. The pin then stays active, because no underflow occurs.
- R10: In one-shot mode, the edge-select bit is applied to the synchronised trigger level, so rewriting that bit can itself register a trigger. With the trigger input held low, switching from rising to falling edge drives the pin active and pulses `irq_trig`.
- R11: Control bit 3 selects how a latch write takes effect. With 0, the high-byte write also loads the counter. With 1, the counter keeps counting and takes the new value at the next underflow.
- R12: Address 1 holds the low latch byte and address 2 the high byte. A low-byte write is staged and changes nothing visible. Only the high-byte write commits the whole 16-bit value.
- R13: Reads of addresses 1 and 2 return the low and high counter bytes, whether the counter runs or is stopped. The latch itself cannot be read back.
- R14: A valid trigger during an active one-shot pulse restarts the count from the latch, so the pulse is extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address: 0 control, 1 low byte, 2 high byte, 3 prescaler select |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data: control, counter low, counter high, or prescaler select |
| trig_in | input | 1 | Asynchronous one-shot trigger input |
| pin_out | output | 1 | Pulse or waveform output level |
| pin_oe | output | 1 | High when the block owns the pin |
| irq_uf | output | 1 | One-cycle underflow interrupt |
| irq_trig | output | 1 | One-cycle trigger interrupt |

## Verification
The bench goes after these corner cases:
- **Staged latch.** A low-byte write alone must leave the counter unchanged. A design that commits half a value would show a corrupted count.
- **Latch-only writes.** The counter must keep its old value until the next underflow. A design that loaded the counter at once would read back the new value early.
- **Stopped trigger.** A trigger while stopped must leave the pin active indefinitely. A design that ended the pulse would drop the pin.
- **Retrigger.** A retrigger must stretch the pulse past its original end. A design that ignored it would end the pulse early.
- **Opposite edge and edge-select rewrite.** The opposite edge must be ignored. A design that accepted it would toggle the pin. Rewriting the edge-select bit with the input held low must fire, and a design that missed this would leave the pin idle.
- **Prescaler clamp.** A select value above 9 must divide by 1024. A design that did not clamp would give a wrong underflow period.

// File: rtl/prt_pkg.sv
// Package: shared types and register addresses for the reload timer.
// Assumes a byte-wide bus with a 2-bit address.
package prt_pkg;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_LO   = 2'd1;
    localparam logic [1:0] ADDR_HI   = 2'd2;
    localparam logic [1:0] ADDR_PSEL = 2'd3;

    localparam logic [2:0] MODE_WAVE    = 3'b100;
    localparam logic [2:0] MODE_ONESHOT = 3'b101;

    // Control byte, MSB first.
    typedef struct packed {
        logic       run;
        logic       edge_rise;
        logic       pol;
        logic       level;
        logic       latch_only;
        logic [2:0] mode;
    } ctrl_t;

endpackage

// File: rtl/prt_prescaler.sv
// Module: power-of-two clock divider.
// Produces a one-cycle tick every 2^(sel+1) cycles while run is high.
// Select values above STAGES-1 are clamped to STAGES-1.
// The divider restarts from zero whenever run is low.
module prt_prescaler #(
    parameter int STAGES = 10,
    parameter int SEL_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam logic [SEL_W-1:0] SEL_MAX = SEL_W'(STAGES - 1);

    logic [STAGES-1:0] pcnt;
    logic [STAGES-1:0] limit;
    logic [SEL_W-1:0]  eff;

    // Clamp the select and build the terminal count as a mask of ones.
    always_comb begin
        eff = (sel > SEL_MAX) ? SEL_MAX : sel;
        for (int i = 0; i < STAGES; i++) begin
            limit[i] = (SEL_W'(i) <= eff);
        end
    end

    assign tick = run && (pcnt == limit);

    // Divider counter: restart when stopped or at the terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pcnt <= '0;
        end else if (!run || tick) begin
            pcnt <= '0;
        end else begin
            pcnt <= pcnt + 1'b1;
        end
    end
endmodule

// File: rtl/prt_trigger.sv
// Module: trigger synchroniser and edge qualifier.
// Applies the edge select to the synchronised level and fires on a
// 0->1 change of the result. Rewriting rise_sel can therefore fire too.
// Assumes trig_in is asynchronous and slower than the clock.
module prt_trigger #(
    parameter int SYNC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic trig_in,
    input  logic rise_sel,
    output logic fire
);
    logic [SYNC-1:0] sr;
    logic            cond;
    logic            cond_d;

    assign cond = rise_sel ? sr[SYNC-1] : ~sr[SYNC-1];
    assign fire = enable && cond && !cond_d;

    // Synchroniser chain for the asynchronous trigger input.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr <= '0;
        end else begin
            sr <= {sr[SYNC-2:0], trig_in};
        end
    end

    // Delayed qualified level. Resets high so reset causes no false edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cond_d <= 1'b1;
        end else begin
            cond_d <= cond;
        end
    end
endmodule

// File: rtl/prt_counter.sv
// Module: down counter with reload.
// A load takes priority over a tick. A tick at zero is an underflow: the
// counter reloads and uf is asserted, unless a load happens in that cycle.
module prt_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic [W-1:0] reload_val,
    output logic [W-1:0] count,
    output logic         uf
);
    assign uf = tick && (count == '0) && !load;

    // Counter update: load, then reload at underflow, then decrement.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (load) begin
            count <= load_val;
        end else if (uf) begin
            count <= reload_val;
        end else if (tick) begin
            count <= count - 1'b1;
        end
    end
endmodule

// File: rtl/prt_outctl.sv
// Module: output pin state machine for waveform and one-shot modes.
// Entering one-shot mode forces the inactive level. In waveform mode an
// underflow copies the level bit. In one-shot mode a trigger drives the
// active level and an underflow restores the inactive level.
module prt_outctl (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] mode,
    input  logic       level,
    input  logic       pol,
    input  logic       enter_os,
    input  logic       enter_pol,
    input  logic       fire,
    input  logic       uf,
    output logic       pin_q
);
    import prt_pkg::*;

    // Pin level register, with mode entry taking priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_q <= 1'b0;
        end else if (enter_os) begin
            pin_q <= enter_pol;
        end else if (mode == MODE_WAVE && uf) begin
            pin_q <= level;
        end else if (mode == MODE_ONESHOT && fire) begin
            pin_q <= ~pol;
        end else if (mode == MODE_ONESHOT && uf) begin
            pin_q <= pol;
        end
    end
endmodule

// File: rtl/pulse_reload_timer.sv
// Module: top of the reload timer with programmable pulse output.
// Holds the bus registers, stages the low latch byte, applies the
// write-control choice, and wires prescaler, trigger, counter and pin logic.
// Assumes single-cycle bus writes and a combinational read path.
module pulse_reload_timer #(
    parameter int W      = 16,
    parameter int STAGES = 10,
    parameter int SEL_W  = 4,
    parameter int SYNC   = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_wr,
    input  logic [1:0] bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       trig_in,
    output logic       pin_out,
    output logic       pin_oe,
    output logic       irq_uf,
    output logic       irq_trig
);
    import prt_pkg::*;

    localparam int HI_W = W - 8;

    ctrl_t            ctrl_q;
    ctrl_t            ctrl_new;
    logic [SEL_W-1:0] psel_q;
    logic [7:0]       lo_stage;
    logic [W-1:0]     latch_q;
    logic [W-1:0]     new_latch;
    logic [W-1:0]     cnt;
    logic             wr_ctrl, wr_lo, wr_hi, wr_psel;
    logic             imm_load, pin_mode, counting, tick, fire, uf, pin_q;
    logic             enter_os, cnt_load;
    logic [W-1:0]     cnt_load_val;
    logic             irq_uf_q, irq_trig_q;

    // Decode the bus write strobes.
    always_comb begin
        wr_ctrl  = bus_wr && bus_addr == ADDR_CTRL;
        wr_lo    = bus_wr && bus_addr == ADDR_LO;
        wr_hi    = bus_wr && bus_addr == ADDR_HI;
        wr_psel  = bus_wr && bus_addr == ADDR_PSEL;
        ctrl_new = ctrl_t'(bus_wdata);
    end

    assign new_latch    = {bus_wdata[HI_W-1:0], lo_stage};
    assign imm_load     = wr_hi && !ctrl_q.latch_only;
    assign pin_mode     = (ctrl_q.mode == MODE_WAVE) || (ctrl_q.mode == MODE_ONESHOT);
    assign counting     = ctrl_q.run && pin_mode;
    assign enter_os     = wr_ctrl && ctrl_new.mode == MODE_ONESHOT
                          && ctrl_q.mode != MODE_ONESHOT;
    assign cnt_load     = imm_load || fire;
    assign cnt_load_val = imm_load ? new_latch : latch_q;

    // Control, prescaler-select, staging and latch registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            psel_q   <= '0;
            lo_stage <= '0;
            latch_q  <= '0;
        end else begin
            if (wr_ctrl) ctrl_q   <= ctrl_new;
            if (wr_psel) psel_q   <= bus_wdata[SEL_W-1:0];
            if (wr_lo)   lo_stage <= bus_wdata;
            if (wr_hi)   latch_q  <= new_latch;
        end
    end

    // Interrupt pulse registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_uf_q   <= 1'b0;
            irq_trig_q <= 1'b0;
        end else begin
            irq_uf_q   <= uf;
            irq_trig_q <= fire;
        end
    end

    prt_prescaler #(.STAGES(STAGES), .SEL_W(SEL_W)) u_presc (
        .clk(clk), .rst_n(rst_n), .run(counting), .sel(psel_q), .tick(tick)
    );

    prt_trigger #(.SYNC(SYNC)) u_trig (
        .clk(clk), .rst_n(rst_n), .enable(ctrl_q.mode == MODE_ONESHOT),
        .trig_in(trig_in), .rise_sel(ctrl_q.edge_rise), .fire(fire)
    );

    prt_counter #(.W(W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .load(cnt_load),
        .load_val(cnt_load_val), .reload_val(latch_q), .count(cnt), .uf(uf)
    );

    prt_outctl u_out (
        .clk(clk), .rst_n(rst_n), .mode(ctrl_q.mode), .level(ctrl_q.level),
        .pol(ctrl_q.pol), .enter_os(enter_os), .enter_pol(ctrl_new.pol),
        .fire(fire), .uf(uf), .pin_q(pin_q)
    );

    // Read mux: the latch has no read path.
    always_comb begin
        case (bus_addr)
            ADDR_CTRL: bus_rdata = ctrl_q;
            ADDR_LO:   bus_rdata = cnt[7:0];
            ADDR_HI:   bus_rdata = 8'(cnt[W-1:8]);
            default:   bus_rdata = 8'(psel_q);
        endcase
    end

    assign pin_oe   = pin_mode;
    assign pin_out  = pin_mode && pin_q;
    assign irq_uf   = irq_uf_q;
    assign irq_trig = irq_trig_q;
endmodule

// File: rtl/prt_checker.sv
// Module: protocol checker bound to pulse_reload_timer.
// Observes the ports plus the control mode, the run bit and the counter.
module prt_checker #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bus_wr,
    input  logic [1:0]   bus_addr,
    input  logic [7:0]   bus_wdata,
    input  logic         pin_out,
    input  logic         pin_oe,
    input  logic         irq_uf,
    input  logic [2:0]   mode_q,
    input  logic         run_q,
    input  logic [W-1:0] cnt
);
    // R4
    uf_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_uf |=> !irq_uf);

    // R2
    pin_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd0 && bus_wdata[2:0] == 3'b000)
        |=> (!pin_oe && !pin_out));

    // R6
    oneshot_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd0 && bus_wdata[2:0] == 3'b101 && mode_q != 3'b101)
        |=> (pin_out == $past(bus_wdata[5])));

    // R5
    wave_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == 3'b100 && $past(mode_q) == 3'b100 && !irq_uf)
        |-> $stable(pin_out));

    // R3
    stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_q && !bus_wr && mode_q != 3'b101) |=> $stable(cnt));
endmodule

bind pulse_reload_timer prt_checker #(.W(W)) u_prt_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .pin_out(pin_out), .pin_oe(pin_oe),
    .irq_uf(irq_uf), .mode_q(ctrl_q.mode), .run_q(ctrl_q.run), .cnt(cnt)
);

// File: tb/pulse_reload_timer_bench.sv
// Directed bench for pulse_reload_timer. One task per scenario.
module pulse_reload_timer_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       trig_in = 1'b0;
    logic       pin_out, pin_oe, irq_uf, irq_trig;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int uf_cnt = 0;
    int trig_cnt = 0;
    int uf_last = 0;
    int uf_prev = 0;
    bit done = 0;

    always #2 clk = ~clk;

    pulse_reload_timer u_pulse_reload_timer (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .trig_in(trig_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq_uf(irq_uf), .irq_trig(irq_trig)
    );

    // Interrupt monitor: counts pulses and stamps underflow times.
    always @(posedge clk) begin
        if (rst_n) begin
            cyc <= cyc + 1;
            if (irq_uf) begin
                uf_cnt  <= uf_cnt + 1;
                uf_prev <= uf_last;
                uf_last <= cyc;
            end
            if (irq_trig) trig_cnt <= trig_cnt + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] ctl(input bit run, input bit rise, input bit pol,
                                       input bit lvl, input bit lonly, input logic [2:0] m);
        return {run, rise, pol, lvl, lonly, m};
    endfunction

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_cnt(output int v);
        logic [7:0] lo;
        @(negedge clk);
        bus_addr = 2'd1; #1 lo = bus_rdata;
        bus_addr = 2'd2; #1 v = {bus_rdata, lo};
    endtask

    task automatic set_latch(input int v);
        wr(2'd1, v[7:0]);
        wr(2'd2, v[15:8]);
    endtask

    task automatic wait_uf();
        int start = uf_cnt;
        int n = 0;
        while (uf_cnt == start && n < 20000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        int v;
        rd_cnt(v);
        chk(pin_oe == 0 && pin_out == 0, "R1 pin", pin_out, 0);
        chk(irq_uf == 0 && irq_trig == 0, "R1 irq", irq_uf, 0);
        chk(v == 0, "R1 counter", v, 0);
        bus_addr = 2'd0; #1;
        chk(bus_rdata[3] == 0, "R1 write control", bus_rdata[3], 0);
    endtask

    task automatic t_release();
        wr(2'd0, ctl(0, 0, 0, 0, 0, 3'b100));
        chk(pin_oe == 1, "R2 wave owns pin", pin_oe, 1);
        wr(2'd0, ctl(0, 0, 0, 1, 0, 3'b011));
        chk(pin_oe == 0 && pin_out == 0, "R2 other code releases", pin_oe, 0);
        wr(2'd0, ctl(0, 0, 0, 0, 0, 3'b000));
        chk(pin_oe == 0, "R2 io code releases", pin_oe, 0);
    endtask

    task automatic t_stage();
        int v;
        set_latch(16'h0000);
        wr(2'd1, 8'h34);
        rd_cnt(v);
        chk(v == 0, "R12 low byte staged", v, 0);
        wr(2'd2, 8'h12);
        rd_cnt(v);
        chk(v == 16'h1234, "R11 R13 immediate load", v, 16'h1234);
        wr(2'd0, ctl(0, 0, 0, 0, 0, 3'b000));
    endtask

    task automatic t_period();
        wr(2'd3, 8'd2);
        set_latch(9);
        wr(2'd0, ctl(1, 0, 0, 0, 0, 3'b100));
        wait_uf(); wait_uf(); wait_uf();
        chk(uf_last - uf_prev == 80, "R3 R4 period div8", uf_last - uf_prev, 80);
        wr(2'd0, ctl(0, 0, 0, 0, 0, 3'b100));
        wr(2'd3, 8'd15);
        set_latch(1);
        wr(2'd0, ctl(1, 0, 0, 0, 0, 3'b100));
        wait_uf(); wait_uf(); wait_uf();
        chk(uf_last - uf_prev == 2048, "R3 clamp div1024", uf_last - uf_prev, 2048);
        wr(2'd0, ctl(0, 0, 0, 0, 0, 3'b100));
    endtask

    task automatic t_wave();
        wr(2'd3, 8'd0);
        set_latch(4);
        wr(2'd0, ctl(1, 0, 0, 1, 0, 3'b100));
        wait_uf();
        chk(pin_out == 1, "R5 level copied high", pin_out, 1);
        wr(2'd0, ctl(1, 0, 0, 0, 0, 3'b100));
        chk(pin_out == 1, "R5 hold until underflow", pin_out, 1);
        wait_uf();
        chk(pin_out == 0, "R5 level copied low", pin_out, 0);
        wr(2'd0, ctl(0, 0, 0, 0, 0, 3'b000));
    endtask

    task automatic t_oneshot();
        int t0;
        trig_in = 0;
        set_latch(9);
        wr(2'd0, ctl(1, 1, 1, 0, 0, 3'b101));
        chk(pin_out == 1, "R6 inactive high", pin_out, 1);
        t0 = trig_cnt;
        trig_in = 1;
        idle(6);
        chk(pin_out == 0, "R7 rising trigger active low", pin_out, 0);
        chk(trig_cnt == t0 + 1, "R7 trigger irq", trig_cnt, t0 + 1);
        wait_uf();
        chk(pin_out == 1, "R7 underflow ends pulse", pin_out, 1);
        t0 = trig_cnt;
        trig_in = 0;
        idle(10);
        chk(pin_out == 1 && trig_cnt == t0, "R8 falling ignored", trig_cnt, t0);
        wr(2'd0, ctl(0, 0, 0, 0, 0, 3'b000));
        wr(2'd0, ctl(1, 0, 0, 0, 0, 3'b101));
        chk(pin_out == 0, "R6 inactive low", pin_out, 0);
        trig_in = 1;
        idle(8);
        chk(pin_out == 0, "R8 rising ignored", pin_out, 0);
        trig_in = 0;
        idle(6);
        chk(pin_out == 1, "R8 falling trigger", pin_out, 1);
        wait_uf();
        chk(pin_out == 0, "R7 pulse ends low", pin_out, 0);
        wr(2'd0, ctl(0, 0, 0, 0, 0, 3'b000));
    endtask

    task automatic t_stopped();
        int u0;
        trig_in = 0;
        wr(2'd0, ctl(0, 1, 0, 0, 0, 3'b101));
        u0 = uf_cnt;
        trig_in = 1;
        idle(6);
        chk(pin_out == 1, "R9 active while stopped", pin_out, 1);
        idle(200);
        chk(pin_out == 1 && uf_cnt == u0, "R9 stays active", pin_out, 1);
        wr(2'd0, ctl(0, 0, 0, 0, 0, 3'b000));
        trig_in = 0;
    endtask

    task automatic t_edge_swap();
        int t0;
        trig_in = 0;
        idle(4);
        wr(2'd0, ctl(0, 1, 0, 0, 0, 3'b101));
        chk(pin_out == 0, "R10 idle before swap", pin_out, 0);
        t0 = trig_cnt;
        wr(2'd0, ctl(0, 0, 0, 0, 0, 3'b101));
        idle(3);
        chk(pin_out == 1 && trig_cnt == t0 + 1, "R10 swap fires", trig_cnt, t0 + 1);
        wr(2'd0, ctl(0, 0, 0, 0, 0, 3'b000));
    endtask

    task automatic t_latch_only();
        int v;
        wr(2'd3, 8'd0);
        set_latch(3);
        wr(2'd0, ctl(0, 0, 0, 0, 1, 3'b100));
        set_latch(16'h1234);
        rd_cnt(v);
        chk(v == 3, "R11 latch only keeps counter", v, 3);
        wr(2'd0, ctl(1, 0, 0, 0, 1, 3'b100));
        wait_uf();
        wr(2'd0, ctl(0, 0, 0, 0, 1, 3'b100));
        rd_cnt(v);
        chk(v <= 16'h1234 && v >= 16'h1220, "R11 R4 new value at underflow", v, 16'h1234);
        wr(2'd0, ctl(0, 0, 0, 0, 0, 3'b000));
    endtask

    task automatic t_retrigger();
        int u0;
        trig_in = 0;
        wr(2'd3, 8'd0);
        set_latch(20);
        wr(2'd0, ctl(1, 1, 0, 0, 0, 3'b101));
        u0 = uf_cnt;
        trig_in = 1;
        idle(20);
        trig_in = 0;
        idle(4);
        trig_in = 1;
        idle(30);
        chk(pin_out == 1 && uf_cnt == u0, "R14 retrigger extends", pin_out, 1);
        idle(30);
        chk(pin_out == 0, "R14 extended pulse ends", pin_out, 0);
        wr(2'd0, ctl(0, 0, 0, 0, 0, 3'b000));
        trig_in = 0;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            chk(0, "watchdog", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_release();
        t_stage();
        t_period();
        t_wave();
        t_oneshot();
        t_stopped();
        t_edge_swap();
        t_latch_only();
        t_retrigger();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule